// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is a single DMA channel that copies a run of elements between one fixed device address and a memory address that moves forward by one element per step. The `to_dev` input picks the direction. When it is high, each element is read from memory and written to the device address. When it is low, each element is read from the device address and written to memory. Every element takes one read beat followed by one write beat on a simple request/grant memory port.

The channel runs in one of two modes, chosen at start.
- **Direct mode** takes its four working words (device address, memory address, size word, link word) straight from the configuration inputs.
- **Chained mode** treats the configuration link word as a pointer. It fetches a 16-byte descriptor from that word-aligned address: device address at +0x0, memory address at +0x4, size word at +0x8, link word at +0xC. It then keeps following link words until one marks the end.

The channel shows its phase on a 2-bit status output. It raises a one-cycle interrupt event when a descriptor asks for one. It raises the interrupt and error events together when a descriptor is malformed or the bus reports a fault.

The states are:
- `S_IDLE`: waits for `start`.
- `S_FETCH`: reads the four descriptor words.
- `S_SETUP`: checks the size word and loads the element counter.
- `S_READ`: the source read beat.
- `S_WRITE`: the destination write beat.
- `S_END`: finishes one descriptor.
- `S_FAIL`: reports a fault.

The transitions are:
- IDLE→SETUP on start in direct mode; IDLE→FETCH on start in chained mode.
- FETCH→FETCH after each granted word; FETCH→SETUP after the fourth word.
- SETUP→READ for a valid non-zero count; SETUP→END for a count of zero; SETUP→FAIL for a bad size word.
- READ→WRITE on grant.
- WRITE→READ on grant while elements remain; WRITE→END on grant of the last element.
- END→FETCH in chained mode with a follow code; END→IDLE otherwise.
- FETCH, READ or WRITE→FAIL on a bus error; FAIL→IDLE.

Top module: `dma_chain_chan`

## Requirements
- R1: After reset, the status output is 0, and `mem_req`, `irq_o` and `err_o` are low.
- R2: Each element is one read beat followed by one write beat. With `to_dev`=1 the read goes to the memory address and the write goes to the device address. With `to_dev`=0 the read goes to the device address and the write goes to the memory address. The write data equals the data read.
- R3: Size word bits 13:12 give the element width: 3 = 1 byte, 2 = 2 bytes, 0 = 4 bytes. The memory address advances by that width per element, and the device address stays fixed. `mem_size` is 0, 1 or 2 (log2 of the byte count) on data beats.
- R4: A size count (bits 11:0) of zero completes with no data beats, and the link code still applies.
- R5: Link bit 0 set on the finishing descriptor gives exactly one `irq_o` pulse, in the first idle (or next-fetch) cycle. Codes 0 and 2 give no pulse.
- R6: In chained mode the channel reads descriptor words at P, P+4, P+8 and P+C, where P is the link word with bits 1:0 cleared. Link code 2 or 3 continues at the next descriptor; code 0 or 1 ends the chain.
- R7: The status output is 0 when idle, 1 during descriptor read, 2 in setup/end/fail, and 3 during data beats. There is no memory request while it is 0.
- R8: `start` has no effect while the status is non-zero.
- R9: A size word is faulty if it has width code 1, any of bits 31:14 set, a count above 0x3FF for 1- or 2-byte widths, or a count above 0x7FF for 4-byte width. A faulty size word pulses `irq_o` and `err_o` together with no data beats. A 4-byte count of 0x400 is valid.
- R10: A granted beat with `mem_err` high ends the job. No further beats follow, and `irq_o` and `err_o` pulse together once.
- R11: While `mem_req` is high and not granted, `mem_req`, `mem_we` and `mem_addr` hold.
- R12: In direct mode, a follow code in the link word fetches no descriptor. Only bit 0 (interrupt) is honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job (sampled while idle) |
| sg_mode | input | 1 | 1 = chained descriptors, 0 = direct registers |
| to_dev | input | 1 | 1 = memory to device, 0 = device to memory |
| cfg_dev_addr | input | 32 | Direct-mode device address |
| cfg_mem_addr | input | 32 | Direct-mode memory address |
| cfg_size | input | 32 | Direct-mode size word |
| cfg_next | input | 32 | Link word / first descriptor pointer |
| chan_status | output | 2 | Phase: 0 idle, 1 descriptor read, 2 wait, 3 access |
| irq_o | output | 1 | One-cycle interrupt event |
| err_o | output | 1 | One-cycle error event (with irq_o) |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = write beat |
| mem_addr | output | 32 | Beat byte address |
| mem_size | output | 2 | log2 of beat byte count |
| mem_wdata | output | 32 | Write data |
| mem_gnt | input | 1 | Beat accepted this cycle |
| mem_rdata | input | 32 | Read data, valid with grant |
| mem_err | input | 1 | Bus fault, valid with grant |

## Verification
Timing counted from the start cycle:
- The status output leaves 0 one cycle after `start` is sampled.
- The first beat is requested two cycles after start in direct mode (through setup), and one cycle after in chained mode.
- Each granted beat is followed by the next request in the following cycle.
- `irq_o` and `err_o` go high one cycle after the END or FAIL state, which is the cycle in which the status already reads 0 (or 1 for a follow).

How the bench keeps to that timing:
- It logs every granted beat at the clock edge where it is accepted.
- It counts event pulses and checks the status beside each one.
- It compares logs and counts only after the status has been 0 for two cycles, so every pulse has landed before a check reads it.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_SETUP,
        S_READ,
        S_WRITE,
        S_END,
        S_FAIL
    } chan_st_t;

    localparam logic [1:0] STAT_IDLE = 2'd0;
    localparam logic [1:0] STAT_DESC = 2'd1;
    localparam logic [1:0] STAT_WAIT = 2'd2;
    localparam logic [1:0] STAT_XFER = 2'd3;

    localparam logic [1:0] WCODE_1B = 2'd3;
    localparam logic [1:0] WCODE_2B = 2'd2;
    localparam logic [1:0] WCODE_4B = 2'd0;

    localparam int LINK_IRQ_BIT    = 0;
    localparam int LINK_FOLLOW_BIT = 1;

endpackage

// File: rtl/dma_size_dec.sv
module dma_size_dec
    import dma_chain_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int CNT_W      = 12,
    parameter int MAX_NARROW = 'h3FF,
    parameter int MAX_WIDE   = 'h7FF
) (
    input  logic [WORD_W-1:0] size_word,
    output logic [CNT_W-1:0]  elem_cnt,
    output logic [2:0]        step_bytes,
    output logic [1:0]        size_log2,
    output logic              bad
);
    localparam int WPOS = 12;

    logic [1:0]  wcode;
    logic        rsvd_set;
    logic [CNT_W-1:0] lim;

    assign wcode    = size_word[WPOS+1:WPOS];
    assign elem_cnt = size_word[CNT_W-1:0];
    assign rsvd_set = |size_word[WORD_W-1:WPOS+2];

    always_comb begin
        step_bytes = 3'd4;
        size_log2  = 2'd2;
        lim        = CNT_W'(MAX_WIDE);
        bad        = rsvd_set;
        unique case (wcode)
            WCODE_1B: begin step_bytes = 3'd1; size_log2 = 2'd0; lim = CNT_W'(MAX_NARROW); end
            WCODE_2B: begin step_bytes = 3'd2; size_log2 = 2'd1; lim = CNT_W'(MAX_NARROW); end
            WCODE_4B: begin step_bytes = 3'd4; size_log2 = 2'd2; lim = CNT_W'(MAX_WIDE);   end
            default:  bad = 1'b1;
        endcase
        if (elem_cnt > lim) bad = 1'b1;
    end
endmodule

// File: rtl/dma_xfer_ctr.sv
module dma_xfer_ctr #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic [CNT_W-1:0]  count,
    input  logic              step,
    input  logic [2:0]        inc,
    output logic [ADDR_W-1:0] addr,
    output logic              last,
    output logic              empty
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr     <= '0;
            remain_q <= '0;
        end else if (load) begin
            addr     <= base;
            remain_q <= count;
        end else if (step) begin
            addr     <= addr + ADDR_W'(inc);
            remain_q <= remain_q - 1'b1;
        end
    end

    assign last  = (remain_q == CNT_W'(1));
    assign empty = (remain_q == '0);

    AST_NO_LOAD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step)); // R3
    AST_STEP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !empty); // R4
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
    import dma_chain_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              sg_mode,
    input  logic              to_dev,
    input  logic [WORD_W-1:0] cfg_dev_addr,
    input  logic [WORD_W-1:0] cfg_mem_addr,
    input  logic [WORD_W-1:0] cfg_size,
    input  logic [WORD_W-1:0] cfg_next,
    output logic [1:0]        chan_status,
    output logic              irq_o,
    output logic              err_o,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_err
);
    localparam int WORDS_PER_DESC = 4;
    localparam int IDX_W = $clog2(WORDS_PER_DESC);

    chan_st_t st_q, st_d;

    logic [WORD_W-1:0] dev_q, base_q, size_q, link_q, ptr_q, data_q;
    logic [IDX_W-1:0]  idx_q;
    logic              sg_q, dir_q, irq_q, err_q;

    logic [CNT_W-1:0]  sz_cnt;
    logic [2:0]        sz_step;
    logic [1:0]        sz_log;
    logic              sz_bad;
    logic [WORD_W-1:0] ctr_addr;
    logic              ctr_last, ctr_empty, ctr_load, ctr_step;
    logic              beat_ok, beat_bad;

    dma_size_dec #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dec (
        .size_word (size_q),
        .elem_cnt  (sz_cnt),
        .step_bytes(sz_step),
        .size_log2 (sz_log),
        .bad       (sz_bad)
    );

    dma_xfer_ctr #(.ADDR_W(WORD_W), .CNT_W(CNT_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .load (ctr_load),
        .base (base_q),
        .count(sz_cnt),
        .step (ctr_step),
        .inc  (sz_step),
        .addr (ctr_addr),
        .last (ctr_last),
        .empty(ctr_empty)
    );

    assign beat_ok  = mem_req && mem_gnt && !mem_err;
    assign beat_bad = mem_req && mem_gnt && mem_err;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (start) st_d = sg_mode ? S_FETCH : S_SETUP;
            S_FETCH: if (beat_bad) st_d = S_FAIL;
                     else if (beat_ok && idx_q == IDX_W'(WORDS_PER_DESC-1)) st_d = S_SETUP;
            S_SETUP: if (sz_bad) st_d = S_FAIL;
                     else if (sz_cnt == '0) st_d = S_END;
                     else st_d = S_READ;
            S_READ:  if (beat_bad) st_d = S_FAIL;
                     else if (beat_ok) st_d = S_WRITE;
            S_WRITE: if (beat_bad) st_d = S_FAIL;
                     else if (beat_ok) st_d = ctr_last ? S_END : S_READ;
            S_END:   st_d = (sg_q && link_q[LINK_FOLLOW_BIT]) ? S_FETCH : S_IDLE;
            S_FAIL:  st_d = S_IDLE;
            default: st_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        mem_addr    = '0;
        mem_size    = sz_log;
        mem_wdata   = data_q;
        chan_status = STAT_WAIT;
        ctr_load    = 1'b0;
        ctr_step    = 1'b0;
        unique case (st_q)
            S_IDLE:  chan_status = STAT_IDLE;
            S_FETCH: begin
                chan_status = STAT_DESC;
                mem_req     = 1'b1;
                mem_addr    = ptr_q + WORD_W'({idx_q, 2'b00});
                mem_size    = 2'd2;
            end
            S_SETUP: ctr_load = !sz_bad;
            S_READ: begin
                chan_status = STAT_XFER;
                mem_req     = 1'b1;
                mem_addr    = dir_q ? ctr_addr : dev_q;
            end
            S_WRITE: begin
                chan_status = STAT_XFER;
                mem_req     = 1'b1;
                mem_we      = 1'b1;
                mem_addr    = dir_q ? dev_q : ctr_addr;
                ctr_step    = beat_ok;
            end
            default: chan_status = STAT_WAIT;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_q <= '0; base_q <= '0; size_q <= '0; link_q <= '0;
            ptr_q <= '0; data_q <= '0; idx_q <= '0;
            sg_q <= 1'b0; dir_q <= 1'b0; irq_q <= 1'b0; err_q <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
            unique case (st_q)
                S_IDLE: if (start) begin
                    sg_q  <= sg_mode;
                    dir_q <= to_dev;
                    idx_q <= '0;
                    if (sg_mode) begin
                        ptr_q <= {cfg_next[WORD_W-1:2], 2'b00};
                    end else begin
                        dev_q  <= cfg_dev_addr;
                        base_q <= cfg_mem_addr;
                        size_q <= cfg_size;
                        link_q <= cfg_next;
                    end
                end
                S_FETCH: if (beat_ok) begin
                    unique case (idx_q)
                        2'd0:    dev_q  <= mem_rdata;
                        2'd1:    base_q <= mem_rdata;
                        2'd2:    size_q <= mem_rdata;
                        default: link_q <= mem_rdata;
                    endcase
                    idx_q <= idx_q + 1'b1;
                end
                S_READ: if (beat_ok) data_q <= mem_rdata;
                S_END: begin
                    irq_q <= link_q[LINK_IRQ_BIT];
                    idx_q <= '0;
                    ptr_q <= {link_q[WORD_W-1:2], 2'b00};
                end
                S_FAIL: begin
                    irq_q <= 1'b1;
                    err_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign irq_o = irq_q;
    assign err_o = err_q;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R11
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R5
    AST_ERR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> irq_o); // R10
    AST_ABORT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_gnt && mem_err) |=> !mem_req); // R10
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_status == STAT_IDLE) |-> !mem_req); // R7
    AST_FETCH_IS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_status == STAT_DESC) |-> (mem_req && !mem_we)); // R6
endmodule

// File: tb/dma_chain_chan_bench.sv
module dma_chain_chan_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, sg_mode = 1'b0, to_dev = 1'b0;
    logic [31:0] cfg_dev_addr = '0, cfg_mem_addr = '0, cfg_size = '0, cfg_next = '0;
    logic [1:0]  chan_status;
    logic        irq_o, err_o, mem_req, mem_we, mem_gnt, mem_err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  mem_size;

    logic        stall_en = 1'b0, err_en = 1'b0;
    logic [31:0] err_addr = '0;
    logic [31:0] cyc = '0;
    logic [31:0] dmem [16];

    int n_chk = 0, n_fail = 0;
    int wcnt, rcnt, irq_cnt, err_cnt, bad_irq_stat, desc_seen;
    logic [31:0] wa [64], wd [64], ra [64];
    logic [1:0]  rs [64];
    logic        done = 1'b0;

    always #10 clk = ~clk;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    assign mem_gnt   = mem_req && !(stall_en && cyc[0]);
    assign mem_err   = mem_req && err_en && (mem_addr == err_addr);
    assign mem_rdata = (mem_addr[31:6] == 26'(32'h1000 >> 6)) ? dmem[mem_addr[5:2]] : pat(mem_addr);

    dma_chain_chan u_dma_chain_chan (
        .clk(clk), .rst_n(rst_n), .start(start), .sg_mode(sg_mode), .to_dev(to_dev),
        .cfg_dev_addr(cfg_dev_addr), .cfg_mem_addr(cfg_mem_addr),
        .cfg_size(cfg_size), .cfg_next(cfg_next),
        .chan_status(chan_status), .irq_o(irq_o), .err_o(err_o),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .mem_err(mem_err)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (mem_req && mem_gnt) begin
                if (mem_we) begin
                    if (wcnt < 64) begin wa[wcnt] = mem_addr; wd[wcnt] = mem_wdata; end
                    wcnt = wcnt + 1;
                end else begin
                    if (rcnt < 64) begin ra[rcnt] = mem_addr; rs[rcnt] = mem_size; end
                    rcnt = rcnt + 1;
                end
            end
            if (irq_o) begin
                irq_cnt = irq_cnt + 1;
                if (chan_status == 2'd2 || chan_status == 2'd3) bad_irq_stat = bad_irq_stat + 1;
            end
            if (err_o) err_cnt = err_cnt + 1;
            if (chan_status == 2'd1) desc_seen = desc_seen + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_logs();
        wcnt = 0; rcnt = 0; irq_cnt = 0; err_cnt = 0; bad_irq_stat = 0; desc_seen = 0;
    endtask

    task automatic go(input logic sg, input logic dir, input logic [31:0] dev,
                      input logic [31:0] mem, input logic [31:0] size, input logic [31:0] nxt);
        @(negedge clk);
        clear_logs();
        sg_mode = sg; to_dev = dir; cfg_dev_addr = dev; cfg_mem_addr = mem;
        cfg_size = size; cfg_next = nxt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (chan_status == 2'd0) break;
            @(negedge clk);
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 status", 32'(chan_status), 0);
        chk("R1 req", 32'(mem_req), 0);
        chk("R1 irq/err", 32'({irq_o, err_o}), 0);
    endtask

    task automatic t_to_mem_4b();
        go(0, 0, 32'h4000_0010, 32'h2000, 32'h0000_0003, 32'h1);
        chk("R2 reads", rcnt, 3);
        chk("R2 writes", wcnt, 3);
        for (int i = 0; i < 3; i++) begin
            chk("R2 read at device", ra[i], 32'h4000_0010);
            chk("R3 write addr step 4", wa[i], 32'h2000 + 32'(4 * i));
            chk("R2 write data", wd[i], pat(32'h4000_0010));
            chk("R3 size 4B", 32'(rs[i]), 2);
        end
        chk("R5 irq once", irq_cnt, 1);
        chk("R5 irq in idle", bad_irq_stat, 0);
        chk("R10 no err", err_cnt, 0);
    endtask

    task automatic t_to_dev_1b();
        go(0, 1, 32'h4000_0020, 32'h3001, 32'h0000_3004, 32'h0);
        chk("R2 writes", wcnt, 4);
        for (int i = 0; i < 4; i++) begin
            chk("R3 read addr step 1", ra[i], 32'h3001 + 32'(i));
            chk("R3 size 1B", 32'(rs[i]), 0);
            chk("R2 write to device", wa[i], 32'h4000_0020);
            chk("R2 data", wd[i], pat(32'h3001 + 32'(i)));
        end
        chk("R5 no irq code 0", irq_cnt, 0);
    endtask

    task automatic t_2b_stall();
        stall_en = 1'b1;
        go(0, 0, 32'h4000_0030, 32'h5000, 32'h0000_2002, 32'h1);
        stall_en = 1'b0;
        chk("R11 writes under stall", wcnt, 2);
        chk("R3 2B first", wa[0], 32'h5000);
        chk("R3 2B second", wa[1], 32'h5002);
        chk("R3 size 2B", 32'(rs[0]), 1);
        chk("R5 irq", irq_cnt, 1);
    endtask

    task automatic t_zero();
        go(0, 0, 32'h4000_0040, 32'h6000, 32'h0, 32'h1);
        chk("R4 no beats", rcnt + wcnt, 0);
        chk("R4 irq", irq_cnt, 1);
        chk("R4 no err", err_cnt, 0);
    endtask

    task automatic t_bad_size();
        go(0, 0, 32'h4000_0050, 32'h6000, 32'h0000_1002, 32'h0);
        chk("R9 width code 1 beats", rcnt + wcnt, 0);
        chk("R9 width code 1 err", err_cnt, 1);
        chk("R9 width code 1 irq", irq_cnt, 1);
        go(0, 0, 32'h4000_0050, 32'h6000, 32'h0000_3400, 32'h0);
        chk("R9 1B over limit err", err_cnt, 1);
        chk("R9 1B over limit beats", rcnt + wcnt, 0);
        go(0, 0, 32'h4000_0050, 32'h6000, 32'h0001_0001, 32'h0);
        chk("R9 reserved bit err", err_cnt, 1);
        go(0, 0, 32'h4000_0050, 32'h8000, 32'h0000_0400, 32'h0);
        chk("R9 4B 0x400 valid", wcnt, 1024);
        chk("R9 4B 0x400 no err", err_cnt, 0);
        chk("R9 4B 0x400 no irq", irq_cnt, 0);
    endtask

    task automatic load_chain(input logic [1:0] code0);
        dmem[0] = 32'h4000_0060; dmem[1] = 32'h6000; dmem[2] = 32'h0000_0002;
        dmem[3] = 32'h1010 | 32'(code0);
        dmem[4] = 32'h4000_0070; dmem[5] = 32'h7000; dmem[6] = 32'h0000_3001;
        dmem[7] = 32'h1;
    endtask

    task automatic t_chain();
        load_chain(2'd2);
        go(1, 0, 32'hDEAD_0000, 32'hDEAD_0000, 32'h0, 32'h1002);
        chk("R6 reads", rcnt, 11);
        for (int i = 0; i < 4; i++) chk("R6 desc0 word", ra[i], 32'h1000 + 32'(4 * i));
        chk("R6 dev0", ra[4], 32'h4000_0060);
        for (int i = 0; i < 4; i++) chk("R6 desc1 word", ra[6 + i], 32'h1010 + 32'(4 * i));
        chk("R6 dev1", ra[10], 32'h4000_0070);
        chk("R6 writes", wcnt, 3);
        chk("R6 w0", wa[0], 32'h6000);
        chk("R6 w1", wa[1], 32'h6004);
        chk("R6 w2", wa[2], 32'h7000);
        chk("R6 w2 data", wd[2], pat(32'h4000_0070));
        chk("R5 irq only at end", irq_cnt, 1);
        chk("R7 desc status seen", 32'(desc_seen > 0), 1);
        load_chain(2'd3);
        go(1, 0, 32'h0, 32'h0, 32'h0, 32'h1000);
        chk("R5 follow with irq gives two", irq_cnt, 2);
        chk("R6 chain writes", wcnt, 3);
    endtask

    task automatic t_direct_follow();
        go(0, 0, 32'h4000_0080, 32'h9000, 32'h0000_0001, 32'h1013);
        chk("R12 no fetch", 32'(desc_seen), 0);
        chk("R12 reads", rcnt, 1);
        chk("R12 irq", irq_cnt, 1);
    endtask

    task automatic t_bus_err();
        err_en = 1'b1; err_addr = 32'hA004;
        go(0, 0, 32'h4000_0090, 32'hA000, 32'h0000_0003, 32'h0);
        err_en = 1'b0;
        chk("R10 writes stop", wcnt, 2);
        chk("R10 reads stop", rcnt, 2);
        chk("R10 err", err_cnt, 1);
        chk("R10 irq", irq_cnt, 1);
        chk("R10 idle", 32'(chan_status), 0);
    endtask

    task automatic t_start_busy();
        @(negedge clk);
        clear_logs();
        stall_en = 1'b1;
        sg_mode = 0; to_dev = 0; cfg_dev_addr = 32'h4000_00A0; cfg_mem_addr = 32'hB000;
        cfg_size = 32'h4; cfg_next = 32'h1; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk); @(negedge clk); @(negedge clk);
        sg_mode = 1; cfg_next = 32'h1000; cfg_mem_addr = 32'hC000; start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 0; i < 1000; i++) begin
            if (chan_status == 2'd0) break;
            @(negedge clk);
        end
        @(negedge clk); @(negedge clk);
        stall_en = 1'b0;
        chk("R8 no fetch", 32'(desc_seen), 0);
        chk("R8 writes", wcnt, 4);
        chk("R8 last addr", wa[3], 32'hB00C);
        chk("R8 single irq", irq_cnt, 1);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) dmem[i] = '0;
        clear_logs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_to_mem_4b();
        t_to_dev_1b();
        t_2b_stall();
        t_zero();
        t_bad_size();
        t_chain();
        t_direct_follow();
        t_bus_err();
        t_start_busy();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(190000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule